// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

The detector sits on the receive path of an Ethernet port. It inspects a frame one byte at a time. It decides whether the frame carries a wake request addressed to this station. A wake request is a run of at least six 0xFF bytes. That run is followed straight away by sixteen back-to-back copies of the station's 48-bit address. The request may begin anywhere in the frame: in the destination or source address fields, or after any number of ordinary payload bytes.

The station address arrives as two configuration words: a 32-bit low word and a 16-bit high word. The low byte of the low word is the byte that travels first on the wire. The matching state is rebuilt from scratch at each start of frame. The verdict is given only when the frame ends. At that point a single-cycle wake pulse is produced if the complete pattern was seen and the receiver reports a good CRC. CRC computation and frame forwarding are done elsewhere.

Top module: `wol_magic_detect`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `wake` is low.
- R2: When the byte marked `eof` is accepted and the frame held a sync run followed by sixteen unbroken address copies, `wake` is high for exactly the next clock cycle. This assumes `crc_ok` is high with that byte.
- R3: Address byte n on the wire (n = 0 first, n = 5 last) must equal bits [8n+7:8n] of {`addr_hi`, `addr_lo`}. Copies sent in any other byte order do not match.
- R4: If `crc_ok` is low when the `eof` byte is accepted, `wake` stays low even for a complete pattern.
- R5: A byte marked `sof` discards all progress from earlier bytes. A pattern split across two frames never wakes, and a one-byte frame never wakes.
- R6: A sync run may hold more than six 0xFF bytes. The first byte after the run that is not 0xFF is taken as the first address byte.
- R7: A run of five or fewer 0xFF bytes is not a sync run.
- R8: A byte that breaks the address sequence restarts the search. If that byte is 0xFF, it counts as the first byte of a new sync run.
- R9: Fifteen address copies after a sync run are not enough to wake. Bytes before the sync run, including header fields, have no effect on a later complete pattern.
- R10: Cycles with `byte_vld` low are ignored, so gaps between bytes do not disturb matching. `wake` is never high in a cycle that does not directly follow an accepted `eof` byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A received byte is present on `byte_dat` this cycle |
| byte_dat | input | 8 | Received byte |
| sof | input | 1 | Qualified by `byte_vld`: this byte is the first of a frame |
| eof | input | 1 | Qualified by `byte_vld`: this byte is the last of a frame |
| crc_ok | input | 1 | Read with the `eof` byte: the frame's CRC was good |
| addr_lo | input | 32 | Station address, wire bytes 0 to 3 (bits [7:0] sent first) |
| addr_hi | input | 16 | Station address, wire bytes 4 and 5 (bits [15:8] sent last) |
| wake | output | 1 | One-cycle pulse after the `eof` byte of a qualifying frame |

## Verification
The detector's only visible output is a verdict at frame end, so a wrong internal state shows up late. A sync counter that loses count, or a byte index that points at the wrong address byte, changes nothing until the cycle after `eof`. In that cycle it shows up as a missing or unexpected pulse. The frames used in checking are therefore built so that each decision point flips the verdict: one FF short of a sync run, one copy short, a byte order swapped, a break byte that is or is not 0xFF. With these frames, any off-by-one in the counters changes the result of that frame.

// File: rtl/wol_pkg.sv
package wol_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_MATCH = 2'd1,
    ST_DONE  = 2'd2
  } wol_state_e;

  typedef enum logic [1:0] {
    FF_HOLD = 2'd0,
    FF_CLR  = 2'd1,
    FF_INC  = 2'd2,
    FF_ONE  = 2'd3
  } ff_op_e;

  typedef enum logic [1:0] {
    RP_HOLD  = 2'd0,
    RP_START = 2'd1,
    RP_ADV   = 2'd2
  } rep_op_e;

  localparam int unsigned WOL_SYNC_LEN = 6;
  localparam int unsigned WOL_REPEATS  = 16;

endpackage

// File: rtl/wol_sync_tracker.sv
module wol_sync_tracker
  import wol_pkg::*;
#(
  parameter int unsigned SYNC_LEN = WOL_SYNC_LEN,
  localparam int unsigned CW = $clog2(SYNC_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ff_op_e        op,
  output logic [CW-1:0] ff_cnt,
  output logic          sync_seen
);

  localparam logic [CW-1:0] CNT_MAX = CW'(SYNC_LEN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b1;
    unique case (op)
      FF_CLR:  cnt_d = '0;
      FF_ONE:  cnt_d = CW'(1);
      FF_INC:  cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(1);
      default: cnt_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ff_cnt    = cnt_q;
  assign sync_seen = (cnt_q == CNT_MAX);

endmodule

// File: rtl/wol_rep_tracker.sv
module wol_rep_tracker
  import wol_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned REPEATS    = WOL_REPEATS,
  localparam int unsigned IW = $clog2(ADDR_BYTES),
  localparam int unsigned RW = (REPEATS > 1) ? $clog2(REPEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rep_op_e       op,
  output logic [IW-1:0] idx,
  output logic          last
);

  localparam logic [IW-1:0] IDX_LAST = IW'(ADDR_BYTES - 1);
  localparam logic [RW-1:0] REP_LAST = RW'(REPEATS - 1);

  logic [IW-1:0] idx_q, idx_d;
  logic [RW-1:0] rep_q, rep_d;
  logic          trk_en;

  always_comb begin
    idx_d  = idx_q;
    rep_d  = rep_q;
    trk_en = 1'b1;
    unique case (op)
      RP_START: begin
        idx_d = IW'(1);
        rep_d = '0;
      end
      RP_ADV: begin
        if (idx_q == IDX_LAST) begin
          idx_d = '0;
          rep_d = rep_q + RW'(1);
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      default: trk_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rep_q <= '0;
    end else if (trk_en) begin
      idx_q <= idx_d;
      rep_q <= rep_d;
    end
  end

  assign idx  = idx_q;
  assign last = (idx_q == IDX_LAST) && (rep_q == REP_LAST);

endmodule

// File: rtl/wol_byte_select.sv
module wol_byte_select #(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned IW = $clog2(ADDR_BYTES)
) (
  input  logic [8*ADDR_BYTES-1:0] station,
  input  logic [IW-1:0]           idx,
  output logic [7:0]              exp_byte
);

  logic [7:0] lane [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    assign lane[g] = station[8*g +: 8];
  end

  always_comb begin
    exp_byte = 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (idx == IW'(i)) exp_byte = lane[i];
    end
  end

endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect
  import wol_pkg::*;
#(
  parameter int unsigned SYNC_LEN = WOL_SYNC_LEN,
  parameter int unsigned REPEATS  = WOL_REPEATS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic [7:0]  byte_dat,
  input  logic        sof,
  input  logic        eof,
  input  logic        crc_ok,
  input  logic [31:0] addr_lo,
  input  logic [15:0] addr_hi,
  output logic        wake
);

  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned CW = $clog2(SYNC_LEN + 1);
  localparam int unsigned IW = $clog2(ADDR_BYTES);

  logic [8*ADDR_BYTES-1:0] station;
  assign station = {addr_hi, addr_lo};

  wol_state_e    state_q, state_d, state_cur;
  ff_op_e        ff_op;
  rep_op_e       rep_op;
  logic [CW-1:0] ff_cnt;
  logic          sync_seen;
  logic [IW-1:0] rep_idx;
  logic          rep_last;
  logic [7:0]    exp_byte;
  logic          is_ff;
  logic          synced;
  logic          wake_d;
  logic          wake_q;

  wol_sync_tracker #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (ff_op),
    .ff_cnt    (ff_cnt),
    .sync_seen (sync_seen)
  );

  wol_rep_tracker #(.ADDR_BYTES(ADDR_BYTES), .REPEATS(REPEATS)) u_rep (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (rep_op),
    .idx   (rep_idx),
    .last  (rep_last)
  );

  wol_byte_select #(.ADDR_BYTES(ADDR_BYTES)) u_sel (
    .station  (station),
    .idx      (rep_idx),
    .exp_byte (exp_byte)
  );

  assign is_ff     = (byte_dat == 8'hFF);
  assign state_cur = sof ? ST_HUNT : state_q;
  assign synced    = sof ? 1'b0 : sync_seen;

  // Next-state decode; a start-of-frame byte is judged from a clean state.
  always_comb begin
    state_d = state_q;
    ff_op   = FF_HOLD;
    rep_op  = RP_HOLD;
    if (byte_vld) begin
      state_d = state_cur;
      unique case (state_cur)
        ST_HUNT: begin
          if (is_ff) begin
            ff_op = sof ? FF_ONE : FF_INC;
          end else if (synced && (byte_dat == station[7:0])) begin
            state_d = ST_MATCH;
            rep_op  = RP_START;
            ff_op   = FF_CLR;
          end else begin
            ff_op = FF_CLR;
          end
        end
        ST_MATCH: begin
          if (byte_dat == exp_byte) begin
            if (rep_last) state_d = ST_DONE;
            else          rep_op  = RP_ADV;
          end else begin
            state_d = ST_HUNT;
            ff_op   = is_ff ? FF_ONE : FF_CLR;
          end
        end
        default: state_d = ST_DONE;
      endcase
    end
  end

  assign wake_d = byte_vld && eof && crc_ok && (state_d == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
    end else if (byte_vld) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
    end else begin
      wake_q <= wake_d;
    end
  end

  assign wake = wake_q;

endmodule

// File: rtl/wol_magic_detect_chk.sv
module wol_magic_detect_chk #(
  parameter int unsigned SYNC_LEN   = 6,
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned CW = $clog2(SYNC_LEN + 1),
  localparam int unsigned IW = $clog2(ADDR_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_vld,
  input logic          sof,
  input logic          eof,
  input logic          crc_ok,
  input logic          wake,
  input logic [CW-1:0] ff_cnt,
  input logic [IW-1:0] rep_idx
);

  localparam logic [CW-1:0] CNT_MAX = CW'(SYNC_LEN);
  localparam logic [IW-1:0] IDX_LIM = IW'(ADDR_BYTES);

  AST_WAKE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(byte_vld && eof)); // R2

  AST_WAKE_NEEDS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(crc_ok)); // R4

  AST_SOF_EOF_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && sof && eof) |=> !wake); // R5

  AST_SYNC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ff_cnt <= CNT_MAX); // R6

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_idx < IDX_LIM); // R3

  AST_IDLE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> !wake); // R10

endmodule

bind wol_magic_detect wol_magic_detect_chk #(
  .SYNC_LEN   (SYNC_LEN),
  .ADDR_BYTES (ADDR_BYTES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .byte_vld (byte_vld),
  .sof      (sof),
  .eof      (eof),
  .crc_ok   (crc_ok),
  .wake     (wake),
  .ff_cnt   (ff_cnt),
  .rep_idx  (rep_idx)
);

// File: tb/wol_magic_detect_test.sv
module wol_magic_detect_test;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        byte_vld;
  logic [7:0]  byte_dat;
  logic        sof;
  logic        eof;
  logic        crc_ok;
  logic [31:0] addr_lo;
  logic [15:0] addr_hi;
  logic        wake;

  int   n_checks;
  int   n_errors;
  exp_t sb[$];
  logic [7:0] frm[$];
  logic last_eof;
  logic [47:0] station;

  wol_magic_detect uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (byte_vld),
    .byte_dat (byte_dat),
    .sof      (sof),
    .eof      (eof),
    .crc_ok   (crc_ok),
    .addr_lo  (addr_lo),
    .addr_hi  (addr_hi),
    .wake     (wake)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) last_eof <= byte_vld && eof;

  // Monitor: compare wake against the scoreboard after each end of frame.
  always @(negedge clk) begin
    if (rst_n) begin
      if (last_eof) begin
        if (sb.size() == 0) begin
          n_checks++;
          n_errors++;
          $display("FAIL R2: frame end with empty scoreboard, wake=%0b expected none", wake);
        end else begin
          exp_t e;
          e = sb.pop_front();
          n_checks++;
          if (wake !== e.exp) begin
            n_errors++;
            $display("FAIL %s: wake=%0b expected %0b", e.tag, wake, e.exp);
          end
        end
      end else if (wake !== 1'b0) begin
        n_errors++;
        $display("FAIL R10: wake=%0b outside end-of-frame slot, expected 0", wake);
      end
    end
  end

  function automatic void f_clear();
    frm.delete();
  endfunction

  function automatic void f_ff(input int n);
    for (int i = 0; i < n; i++) frm.push_back(8'hFF);
  endfunction

  function automatic void f_byte(input logic [7:0] b);
    frm.push_back(b);
  endfunction

  // R3: wire byte n = station[8n+7:8n]
  function automatic void f_addr(input int reps, input bit reversed);
    for (int r = 0; r < reps; r++)
      for (int n = 0; n < 6; n++)
        frm.push_back(reversed ? station[8*(5-n) +: 8] : station[8*n +: 8]);
  endfunction

  function automatic void f_hdr(input bit bcast);
    for (int n = 0; n < 6; n++) frm.push_back(bcast ? 8'hFF : station[8*n +: 8]);
    for (int n = 0; n < 6; n++) frm.push_back(8'h02 + 8'(n));
    frm.push_back(8'h08);
    frm.push_back(8'h42);
  endfunction

  function automatic void f_crc();
    frm.push_back(8'hA5); frm.push_back(8'h3C);
    frm.push_back(8'h0F); frm.push_back(8'h71);
  endfunction

  task automatic send_frame(input logic good, input logic expw, input string tag, input int gap);
    exp_t e;
    e.exp = expw;
    e.tag = tag;
    sb.push_back(e);
    for (int i = 0; i < frm.size(); i++) begin
      byte_vld = 1'b1;
      byte_dat = frm[i];
      sof      = (i == 0);
      eof      = (i == frm.size() - 1);
      crc_ok   = (i == frm.size() - 1) ? good : 1'b0;
      @(negedge clk);
      if (gap > 0 && i != frm.size() - 1) begin
        byte_vld = 1'b0;
        sof      = 1'b0;
        eof      = 1'b0;
        byte_dat = 8'hFF;
        repeat (gap) @(negedge clk);
      end
    end
    byte_vld = 1'b0;
    sof      = 1'b0;
    eof      = 1'b0;
    crc_ok   = 1'b0;
    byte_dat = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    rst_n    = 1'b0;
    byte_vld = 1'b0;
    byte_dat = 8'h00;
    sof      = 1'b0;
    eof      = 1'b0;
    crc_ok   = 1'b0;
    addr_lo  = 32'h78563412;
    addr_hi  = 16'hBC9A;
    station  = {16'hBC9A, 32'h78563412};
    repeat (3) @(negedge clk);
    n_checks++;
    if (wake !== 1'b0) begin
      n_errors++;
      $display("FAIL R1: wake=%0b in reset, expected 0", wake);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (wake !== 1'b0) begin
      n_errors++;
      $display("FAIL R1: wake=%0b after reset, expected 0", wake);
    end

    // R2 and R9: unicast header, then exact pattern
    f_clear(); f_hdr(1'b0); f_ff(6); f_addr(16, 1'b0); f_crc();
    send_frame(1'b1, 1'b1, "R2", 0);

    // R4: same frame, bad CRC
    send_frame(1'b0, 1'b0, "R4", 0);

    // R6: broadcast header, long sync run
    f_clear(); f_hdr(1'b1); f_byte(8'h11); f_ff(9); f_addr(16, 1'b0); f_crc();
    send_frame(1'b1, 1'b1, "R6", 0);

    // R7: five FF only
    f_clear(); f_hdr(1'b0); f_ff(5); f_addr(16, 1'b0); f_crc();
    send_frame(1'b1, 1'b0, "R7", 0);

    // R9: fifteen copies
    f_clear(); f_hdr(1'b0); f_ff(6); f_addr(15, 1'b0); f_crc();
    send_frame(1'b1, 1'b0, "R9", 0);

    // R3: reversed byte order
    f_clear(); f_hdr(1'b0); f_ff(6); f_addr(16, 1'b1); f_crc();
    send_frame(1'b1, 1'b0, "R3", 0);

    // R8: break byte 0xFF starts a new sync run
    f_clear(); f_hdr(1'b0); f_ff(6); f_addr(3, 1'b0); f_byte(8'hFF);
    f_ff(5); f_addr(16, 1'b0); f_crc();
    send_frame(1'b1, 1'b1, "R8", 0);

    // R8: non-FF break byte, only five FF afterwards
    f_clear(); f_hdr(1'b0); f_ff(6); f_addr(2, 1'b0); f_byte(8'h00);
    f_ff(5); f_addr(16, 1'b0); f_crc();
    send_frame(1'b1, 1'b0, "R8", 0);

    // R5: pattern split across two frames
    f_clear(); f_hdr(1'b0); f_ff(6); f_addr(10, 1'b0);
    send_frame(1'b1, 1'b0, "R5", 0);
    f_clear(); f_addr(6, 1'b0); f_crc();
    send_frame(1'b1, 1'b0, "R5", 0);

    // R5: one-byte frame
    f_clear(); f_byte(8'hFF);
    send_frame(1'b1, 1'b0, "R5", 0);

    // R10: idle gaps between bytes
    f_clear(); f_hdr(1'b0); f_ff(7); f_addr(16, 1'b0); f_crc();
    send_frame(1'b1, 1'b1, "R10", 2);

    // R10: pulse lasts one cycle
    f_clear(); f_hdr(1'b0); f_ff(6); f_addr(16, 1'b0);
    send_frame(1'b1, 1'b1, "R10", 0);
    n_checks++;
    if (wake !== 1'b0) begin
      n_errors++;
      $display("FAIL R10: wake=%0b after pulse, expected 0", wake);
    end

    n_checks++;
    if (sb.size() != 0) begin
      n_errors++;
      $display("FAIL R2: %0d verdicts missing, expected 0", sb.size());
    end
    summary();
    $finish;
  end

endmodule